// File: doc/BRIEF.md
# Block-Write Masked Memory Port

This block models the random-access side of a 16-bit video frame memory. The array is scaled down and its size is set by parameters. Commands arrive one per clock on a synchronous interface. Each command carries an opcode, a row, a column, a 16-bit data word, two byte enables and a mask-enable flag. The block keeps two registers beside the array. The write mask is a persistent per-bit gate: a bit set to one lets that data bit be written. The color register holds the fill word used by block writes.

A block write fills an aligned group of adjacent columns in one row with the color word, all in one cycle. The group size is a parameter and is 4 or 8 columns. The low data-input bits choose which columns of the group receive the color. Byte enables take part in every command type. When the command's mask-enable flag is set, the mask register further limits which bits a write changes. Reads return data one cycle after the command.

Top module: `bwmp_top`

## Requirements
- R1: Reset clears the whole array, the write mask and the color register to zero, and holds `rdValid` low.
- R2: A write (opcode 1) with `cmdMaskEn` low stores `cmdData` into the byte lanes whose enables are set. Enable bit 0 selects bits 7:0 and bit 1 selects bits 15:8. Other lanes keep their old value.
- R3: A read (opcode 2) drives `rdValid` high and `rdData` with the stored word on the cycle after the command. Each byte lane whose enable is clear reads as zero. `rdValid` is low after every other command.
- R4: A load-mask command (opcode 4) copies `cmdData` into the mask register, but only in the enabled byte lanes.
- R5: A write with `cmdMaskEn` high stores `(old & ~mask) | (new & mask)` in the enabled byte lanes. Disabled lanes are left unchanged.
- R6: The mask register keeps its value across any number of other commands until the next load-mask command.
- R7: A load-color command (opcode 5) copies `cmdData` into the color register, but only in the enabled byte lanes. The register holds that value otherwise.
- R8: A block write (opcode 3) covers columns `base + i`, where `base` is `cmdCol` with its low log2(BLOCK_COLS) bits cleared. For each such column, it writes the color register only when `cmdData[i]` is set. Unselected columns keep their value.
- R9: Block writes honour the byte enables, and they also apply the write mask when `cmdMaskEn` is high.
- R10: A block write changes no word outside its own row and aligned column group.
- R11: A cycle with `cmdValid` low, or with opcode 0, 6 or 7, changes neither the array nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Opcode: 0 idle, 1 write, 2 read, 3 block write, 4 load mask, 5 load color |
| cmdRow | input | ROW_BITS | Row address |
| cmdCol | input | COL_BITS | Column address |
| cmdData | input | 16 | Write data, register load value, or block column select |
| cmdByteEn | input | 2 | Byte-lane enables (bit 0 = bits 7:0) |
| cmdMaskEn | input | 1 | Apply the write mask to this write or block write |
| rdData | output | 16 | Read data, valid one cycle after a read |
| rdValid | output | 1 | High on the cycle that rdData carries a read result |

## Verification
On every cycle, the assertions check a set of local rules. The mask and color registers hold their value unless a load targets them. A disabled byte lane of a load leaves that lane unchanged. The decoder never raises two strobes at once. A storage word without a write strobe keeps its value. A read always raises `rdValid` one cycle later with zeroed disabled lanes. The arithmetic of a masked merge, the column selection and alignment of block writes, and the isolation of neighbouring rows and groups depend on what was stored earlier. Only the bench's scenarios show those: they write known patterns and read them back.

// File: rtl/bwmp_pkg.sv
package bwmp_pkg;

  localparam int WORD_W = 16;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_WRITE   = 3'd1,
    OP_READ    = 3'd2,
    OP_BLOCK   = 3'd3,
    OP_LDMASK  = 3'd4,
    OP_LDCOLOR = 3'd5
  } opcode_e;

  // Strobes sent from the decoder to the datapath
  typedef struct packed {
    logic             wrWord;
    logic             wrBlock;
    logic             rdWord;
    logic             ldMask;
    logic             ldColor;
    logic             useMask;
    logic [LANES-1:0] byteEn;
  } strobe_t;

  function automatic logic [WORD_W-1:0] laneBits(input logic [LANES-1:0] be);
    logic [WORD_W-1:0] bits;
    for (int i = 0; i < LANES; i++) bits[i*8 +: 8] = {8{be[i]}};
    return bits;
  endfunction

endpackage

// File: rtl/bwmp_ctrl.sv
module bwmp_ctrl
  import bwmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [LANES-1:0] cmdByteEn,
  input  logic             cmdMaskEn,
  output strobe_t          stb
);

  always_comb begin
    stb         = '0;
    stb.byteEn  = cmdByteEn;
    stb.useMask = cmdMaskEn;
    if (cmdValid) begin
      case (opcode_e'(cmdOp))
        OP_WRITE:   stb.wrWord  = 1'b1;
        OP_READ:    stb.rdWord  = 1'b1;
        OP_BLOCK:   stb.wrBlock = 1'b1;
        OP_LDMASK:  stb.ldMask  = 1'b1;
        OP_LDCOLOR: stb.ldColor = 1'b1;
        default:    ;
      endcase
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrWord, stb.wrBlock, stb.rdWord, stb.ldMask, stb.ldColor})); // R11

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> !(stb.wrWord || stb.wrBlock || stb.ldMask || stb.ldColor)); // R11

endmodule

// File: rtl/bwmp_cell.sv
module bwmp_cell
  import bwmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] newData,
  input  logic [WORD_W-1:0] bitEn,
  output logic [WORD_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rstN)     q <= '0;
    else if (wrEn) q <= (q & ~bitEn) | (newData & bitEn);
  end

  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(q)); // R11

endmodule

// File: rtl/bwmp_datapath.sv
module bwmp_datapath
  import bwmp_pkg::*;
#(
  parameter int ROW_BITS   = 2,
  parameter int COL_BITS   = 4,
  parameter int BLOCK_COLS = 4
)(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [ROW_BITS-1:0] cmdRow,
  input  logic [COL_BITS-1:0] cmdCol,
  input  logic [WORD_W-1:0]   cmdData,
  output logic [WORD_W-1:0]   rdData,
  output logic                rdValid
);

  localparam int COLS      = 1 << COL_BITS;
  localparam int DEPTH     = COLS << ROW_BITS;
  localparam int ADDR_BITS = ROW_BITS + COL_BITS;
  localparam int SEL_BITS  = $clog2(BLOCK_COLS);
  localparam int GRP_BITS  = COL_BITS - SEL_BITS;

  logic [WORD_W-1:0]    maskReg;
  logic [WORD_W-1:0]    colorReg;
  logic [WORD_W-1:0]    laneMask;
  logic [WORD_W-1:0]    wrBitEn;
  logic [WORD_W-1:0]    wrSource;
  logic [ADDR_BITS-1:0] wordIdx;
  logic [GRP_BITS-1:0]  grpIdx;
  logic [WORD_W-1:0]    cellQ [DEPTH];

  assign laneMask = laneBits(stb.byteEn);
  assign wrBitEn  = laneMask & (stb.useMask ? maskReg : {WORD_W{1'b1}});
  assign wrSource = stb.wrBlock ? colorReg : cmdData;
  assign wordIdx  = {cmdRow, cmdCol};
  assign grpIdx   = cmdCol[COL_BITS-1:SEL_BITS];

  // Register loads, byte-lane gated
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg  <= '0;
      colorReg <= '0;
    end else begin
      if (stb.ldMask)  maskReg  <= (maskReg  & ~laneMask) | (cmdData & laneMask);
      if (stb.ldColor) colorReg <= (colorReg & ~laneMask) | (cmdData & laneMask);
    end
  end

  // Storage words with per-word write decode
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam int W_COL  = w % COLS;
    localparam int W_ROW  = w / COLS;
    localparam int W_LANE = W_COL % BLOCK_COLS;
    localparam int W_GRP  = W_COL / BLOCK_COLS;
    logic plainHit;
    logic blockHit;
    logic [WORD_W-1:0] q;

    assign plainHit = stb.wrWord && (wordIdx == ADDR_BITS'(w));
    assign blockHit = stb.wrBlock && (cmdRow == ROW_BITS'(W_ROW)) &&
                      (grpIdx == GRP_BITS'(W_GRP)) && cmdData[W_LANE];

    bwmp_cell u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (plainHit || blockHit),
      .newData (wrSource),
      .bitEn   (wrBitEn),
      .q       (q)
    );
    assign cellQ[w] = q;
  end

  // Registered read with lane zeroing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdWord;
      if (stb.rdWord) rdData <= cellQ[wordIdx] & laneMask;
    end
  end

  AST_MASK_PERSISTS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldMask |=> $stable(maskReg)); // R6

  AST_COLOR_PERSISTS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldColor |=> $stable(colorReg)); // R7

  AST_MASK_LOW_LANE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldMask && !stb.byteEn[0]) |=> maskReg[7:0] == $past(maskReg[7:0])); // R4

  AST_MASK_HIGH_LANE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldMask && !stb.byteEn[1]) |=> maskReg[15:8] == $past(maskReg[15:8])); // R4

  AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdWord |=> rdValid); // R3

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdWord |=> !rdValid); // R3

  AST_READ_LOW_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdWord && !stb.byteEn[0]) |=> rdData[7:0] == 8'h00); // R3

  AST_READ_HIGH_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdWord && !stb.byteEn[1]) |=> rdData[15:8] == 8'h00); // R3

endmodule

// File: rtl/bwmp_top.sv
module bwmp_top #(
  parameter int ROW_BITS   = 2,
  parameter int COL_BITS   = 4,
  parameter int BLOCK_COLS = 4
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [2:0]          cmdOp,
  input  logic [ROW_BITS-1:0] cmdRow,
  input  logic [COL_BITS-1:0] cmdCol,
  input  logic [15:0]         cmdData,
  input  logic [1:0]          cmdByteEn,
  input  logic                cmdMaskEn,
  output logic [15:0]         rdData,
  output logic                rdValid
);

  bwmp_pkg::strobe_t stb;

  bwmp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdByteEn (cmdByteEn),
    .cmdMaskEn (cmdMaskEn),
    .stb       (stb)
  );

  bwmp_datapath #(
    .ROW_BITS   (ROW_BITS),
    .COL_BITS   (COL_BITS),
    .BLOCK_COLS (BLOCK_COLS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cmdRow  (cmdRow),
    .cmdCol  (cmdCol),
    .cmdData (cmdData),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  AST_RESET_NO_VALID: assert property (@(posedge clk)
    !rstN |=> !rdValid); // R1

endmodule

// File: tb/bwmp_top_tb_top.sv
module bwmp_top_tb_top;

  typedef struct packed {
    logic        valid;
    logic [2:0]  op;
    logic [1:0]  row;
    logic [3:0]  col;
    logic [15:0] data;
    logic [1:0]  be;
    logic        mEn;
    logic        chk;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  // valid, op, row, col, data, be, mEn, chk, exp, req
  localparam vec_t VECS [NV] = '{
    vec_t'({1'b1, 3'd1, 2'd0, 4'd0,  16'hA5A5, 2'd3, 1'b0, 1'b0, 16'h0000, 4'd2}),  // R2 plain write
    vec_t'({1'b1, 3'd2, 2'd0, 4'd0,  16'h0000, 2'd3, 1'b0, 1'b1, 16'hA5A5, 4'd2}),  // R2 readback
    vec_t'({1'b1, 3'd2, 2'd0, 4'd0,  16'h0000, 2'd1, 1'b0, 1'b1, 16'h00A5, 4'd3}),  // R3 high lane off
    vec_t'({1'b1, 3'd2, 2'd0, 4'd0,  16'h0000, 2'd2, 1'b0, 1'b1, 16'hA500, 4'd3}),  // R3 low lane off
    vec_t'({1'b1, 3'd1, 2'd0, 4'd1,  16'h1234, 2'd1, 1'b0, 1'b0, 16'h0000, 4'd2}),  // R2 low byte only
    vec_t'({1'b1, 3'd2, 2'd0, 4'd1,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h0034, 4'd2}),  // R2
    vec_t'({1'b1, 3'd4, 2'd0, 4'd0,  16'hFFFF, 2'd1, 1'b0, 1'b0, 16'h0000, 4'd4}),  // R4 mask=00FF
    vec_t'({1'b1, 3'd4, 2'd0, 4'd0,  16'h0F0F, 2'd2, 1'b0, 1'b0, 16'h0000, 4'd4}),  // R4 mask=0FFF
    vec_t'({1'b1, 3'd1, 2'd1, 4'd0,  16'hFFFF, 2'd3, 1'b1, 1'b0, 16'h0000, 4'd5}),  // R5 masked write
    vec_t'({1'b1, 3'd2, 2'd1, 4'd0,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h0FFF, 4'd4}),  // R4/R5
    vec_t'({1'b1, 3'd1, 2'd1, 4'd1,  16'hABCD, 2'd3, 1'b0, 1'b0, 16'h0000, 4'd6}),  // R6 setup
    vec_t'({1'b1, 3'd1, 2'd1, 4'd1,  16'h0000, 2'd3, 1'b1, 1'b0, 16'h0000, 4'd6}),  // R6 mask reused
    vec_t'({1'b1, 3'd2, 2'd1, 4'd1,  16'h0000, 2'd3, 1'b0, 1'b1, 16'hA000, 4'd6}),  // R6
    vec_t'({1'b1, 3'd1, 2'd1, 4'd2,  16'hFFFF, 2'd3, 1'b0, 1'b0, 16'h0000, 4'd5}),  // R5 setup
    vec_t'({1'b1, 3'd1, 2'd1, 4'd2,  16'h0000, 2'd1, 1'b1, 1'b0, 16'h0000, 4'd5}),  // R5 masked, low lane
    vec_t'({1'b1, 3'd2, 2'd1, 4'd2,  16'h0000, 2'd3, 1'b0, 1'b1, 16'hFF00, 4'd5}),  // R5
    vec_t'({1'b1, 3'd5, 2'd0, 4'd0,  16'h5AC3, 2'd3, 1'b0, 1'b0, 16'h0000, 4'd7}),  // R7 color=5AC3
    vec_t'({1'b1, 3'd5, 2'd0, 4'd0,  16'h1111, 2'd2, 1'b0, 1'b0, 16'h0000, 4'd7}),  // R7 color=11C3
    vec_t'({1'b1, 3'd3, 2'd2, 4'd6,  16'h000A, 2'd3, 1'b0, 1'b0, 16'h0000, 4'd8}),  // R8 cols 5,7
    vec_t'({1'b1, 3'd2, 2'd2, 4'd4,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h0000, 4'd8}),  // R8
    vec_t'({1'b1, 3'd2, 2'd2, 4'd5,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h11C3, 4'd8}),  // R8 / R7
    vec_t'({1'b1, 3'd2, 2'd2, 4'd6,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h0000, 4'd8}),  // R8
    vec_t'({1'b1, 3'd2, 2'd2, 4'd7,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h11C3, 4'd8}),  // R8
    vec_t'({1'b1, 3'd2, 2'd2, 4'd8,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h0000, 4'd10}), // R10 next group
    vec_t'({1'b1, 3'd2, 2'd3, 4'd5,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h0000, 4'd10}), // R10 other row
    vec_t'({1'b1, 3'd3, 2'd2, 4'd4,  16'h0001, 2'd3, 1'b1, 1'b0, 16'h0000, 4'd9}),  // R9 masked block
    vec_t'({1'b1, 3'd2, 2'd2, 4'd4,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h01C3, 4'd9}),  // R9
    vec_t'({1'b1, 3'd2, 2'd2, 4'd5,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h11C3, 4'd8}),  // R8 unselected kept
    vec_t'({1'b1, 3'd3, 2'd2, 4'd9,  16'h000F, 2'd1, 1'b0, 1'b0, 16'h0000, 4'd9}),  // R9 low lane block
    vec_t'({1'b1, 3'd2, 2'd2, 4'd9,  16'h0000, 2'd3, 1'b0, 1'b1, 16'h00C3, 4'd9}),  // R9
    vec_t'({1'b1, 3'd2, 2'd2, 4'd11, 16'h0000, 2'd3, 1'b0, 1'b1, 16'h00C3, 4'd9}),  // R9
    vec_t'({1'b0, 3'd1, 2'd0, 4'd0,  16'h0000, 2'd3, 1'b0, 1'b0, 16'h0000, 4'd11}), // R11 not valid
    vec_t'({1'b1, 3'd6, 2'd0, 4'd0,  16'h0000, 2'd3, 1'b0, 1'b0, 16'h0000, 4'd11}), // R11 unused op
    vec_t'({1'b1, 3'd2, 2'd0, 4'd0,  16'h0000, 2'd3, 1'b0, 1'b1, 16'hA5A5, 4'd11})  // R11
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [2:0]  cmdOp;
  logic [1:0]  cmdRow;
  logic [3:0]  cmdCol;
  logic [15:0] cmdData;
  logic [1:0]  cmdByteEn;
  logic        cmdMaskEn;
  logic [15:0] rdData;
  logic        rdValid;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  bwmp_top dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdRow    (cmdRow),
    .cmdCol    (cmdCol),
    .cmdData   (cmdData),
    .cmdByteEn (cmdByteEn),
    .cmdMaskEn (cmdMaskEn),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

  task automatic check(input int req, input logic [16:0] act, input logic [16:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, return at the next falling edge
  task automatic issue(input logic v, input logic [2:0] op, input logic [1:0] r,
                       input logic [3:0] c, input logic [15:0] d,
                       input logic [1:0] be, input logic m);
    cmdValid = v; cmdOp = op; cmdRow = r; cmdCol = c;
    cmdData = d; cmdByteEn = be; cmdMaskEn = m;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = '0; cmdRow = '0; cmdCol = '0;
    cmdData = '0; cmdByteEn = '0; cmdMaskEn = 1'b0;
    repeat (3) @(negedge clk);
    check(1, {rdValid, rdData}, 17'h0_0000);                  // R1 outputs in reset
    rstN = 1'b1;

    // R1: array cleared, mask zero, color zero
    issue(1'b1, 3'd2, 2'd3, 4'd2, 16'h0, 2'd3, 1'b0);
    check(1, {rdValid, rdData}, {1'b1, 16'h0000});            // R1 array zero
    issue(1'b1, 3'd1, 2'd3, 4'd3, 16'hFFFF, 2'd3, 1'b1);
    issue(1'b1, 3'd2, 2'd3, 4'd3, 16'h0, 2'd3, 1'b0);
    check(1, {rdValid, rdData}, {1'b1, 16'h0000});            // R1 mask zero blocks all
    issue(1'b1, 3'd1, 2'd3, 4'd0, 16'hFFFF, 2'd3, 1'b0);
    issue(1'b1, 3'd3, 2'd3, 4'd0, 16'h0001, 2'd3, 1'b0);
    issue(1'b1, 3'd2, 2'd3, 4'd0, 16'h0, 2'd3, 1'b0);
    check(1, {rdValid, rdData}, {1'b1, 16'h0000});            // R1 color zero

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].valid, VECS[i].op, VECS[i].row, VECS[i].col,
            VECS[i].data, VECS[i].be, VECS[i].mEn);
      if (VECS[i].chk) check(int'(VECS[i].req), {rdValid, rdData}, {1'b1, VECS[i].exp});
      else             check(3, {16'h0, rdValid}, 17'h0);      // R3 no valid after non-read
    end

    // R11: a read with cmdValid low gives no result
    issue(1'b0, 3'd2, 2'd0, 4'd0, 16'h0, 2'd3, 1'b0);
    check(11, {16'h0, rdValid}, 17'h0);

    // R1: reset mid-run clears stored data again
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    issue(1'b1, 3'd2, 2'd0, 4'd0, 16'h0, 2'd3, 1'b0);
    check(1, {rdValid, rdData}, {1'b1, 16'h0000});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule